// File: doc/BRIEF.md
# Error and Event Interrupt Status Aggregator

This block holds the 32-bit interrupt status word of a bus-bridge address translation unit. Single-cycle event pulses from the link, configuration and error logic land in sticky status bits. Software acknowledges an event by writing a one to its bit. Two bits are not stored at all: they are computed every cycle from external error-status vectors and their masks, and they clear only when those sources clear.

A small power-state tracker follows the writes to the power-state field. It has four states, `PS_D0`, `PS_D1`, `PS_D2` and `PS_D3`, with encodings 0 to 3 of the 2-bit field. A write moves the tracker to the written state. Only four moves raise the transition event: `PS_D0`->`PS_D3`, `PS_D0`->`PS_D1`, `PS_D1`->`PS_D3` and `PS_D3`->`PS_D0`. Every other move, and every write of the current state, is silent.

Two level-sensitive interrupt lines are produced and registered. The configuration-write line covers bits 17:16. The error line covers bits 13:4 except bit 6. Each line is gated bit by bit by its own enable vector.

Top module: `evt_irq_status`

## Requirements
- R1: After reset `status_o` is 0 and both interrupt outputs are 0.
- R2: The sticky bits are 17, 16, 13, 12, 9, 8, 7, 6, 5 and 4. A write with `wr_en_i`=1 clears each sticky bit whose `wr_data_i` bit is 1, from the next cycle on. A 0 in the write data leaves that bit unchanged.
- R3: If a set event and a clearing write hit the same sticky bit in the same cycle, the bit ends up set.
- R4: A pulse on `vpd_addr_wr_i` sets bit 17 in the following cycle.
- R5: Bit 16 sets after a power-state write (`pm_wr_en_i`, new state on `pm_state_i`, 0=D0 1=D1 2=D2 3=D3) only for the moves D0->D3, D0->D1, D1->D3 and D3->D0. Other moves, and writes of the unchanged state, leave it clear. The tracker starts in D0 after reset.
- R6: `posted_par_err_i` sets bit 13 only while `halt_on_err_i` is 1. It has no effect while `halt_on_err_i` is 0.
- R7: Bit 11 reads, in the same cycle, as the OR of bits 6, 5 and 0 of `root_err_sts_i`. Writes do not change it.
- R8: Bit 10 reads, in the same cycle, as the OR of `pie_sts_i & ~pie_msk_i`. Writes do not change it.
- R9: Bits 31:18, 15:14 and 3:0 always read 0, whatever is written.
- R10: Event pulses set these bits: `root_syserr_i` bit 12, `cor_msg_tx_i` bit 9, `unc_msg_tx_i` bit 8, `cfg_retry_i` bit 7, `link_down_i` bit 6, `ibus_mabort_i` bit 5 and `poison_rx_i` bit 4.
- R11: `irq_cfg_o` equals, one cycle later, the OR of `status_o[17:16] & cfg_irq_en_i[17:16]`.
- R12: `irq_err_o` equals, one cycle later, the OR of `status_o & err_irq_en_i` over bits 13:4. Bit 6 is left out, so bit 6 never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Status write strobe |
| wr_data_i | input | 32 | Write-one-to-clear data |
| status_o | output | 32 | Status word as read by software |
| vpd_addr_wr_i | input | 1 | Pulse: configuration write to the product-data address register |
| pm_wr_en_i | input | 1 | Pulse: power-state field written |
| pm_state_i | input | 2 | Power state being written |
| halt_on_err_i | input | 1 | Halt-on-error control level |
| posted_par_err_i | input | 1 | Pulse: outbound parity error on a posted write |
| root_syserr_i | input | 1 | Pulse: unmasked error message with system-error reporting on |
| cor_msg_tx_i | input | 1 | Pulse: correctable error message sent |
| unc_msg_tx_i | input | 1 | Pulse: uncorrectable error message sent |
| cfg_retry_i | input | 1 | Pulse: configuration completion with retry status |
| link_down_i | input | 1 | Pulse: link went down |
| ibus_mabort_i | input | 1 | Pulse: internal bus master abort |
| poison_rx_i | input | 1 | Pulse: poisoned packet received |
| root_err_sts_i | input | ROOT_W | External root-error status vector |
| pie_sts_i | input | PIE_W | External interface-error status vector |
| pie_msk_i | input | PIE_W | Mask for the interface-error vector, 1 = masked |
| cfg_irq_en_i | input | 32 | Per-bit enables for the configuration-write line |
| err_irq_en_i | input | 32 | Per-bit enables for the error line |
| irq_cfg_o | output | 1 | Configuration-write interrupt, registered level |
| irq_err_o | output | 1 | Error interrupt, registered level |

## Verification
The temporal checks assume that every event input is sampled at a clock edge and that the external status and mask vectors change only between edges. The checks measure a bit's next value against the previous cycle's pulse and write. The bench drives all inputs on the falling edge and holds pulses for exactly one cycle, so each pulse is seen at one rising edge only. The power-state field is written only with legal 2-bit codes. The halt control is changed only while no parity-error pulse is active.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int STAT_W = 32;

    // Bit positions are part of the software-visible layout.
    localparam int B_VPD    = 17;
    localparam int B_PSTATE = 16;
    localparam int B_HALT   = 13;
    localparam int B_SYSERR = 12;
    localparam int B_ROOT   = 11;
    localparam int B_PIE    = 10;
    localparam int B_CORTX  = 9;
    localparam int B_UNCTX  = 8;
    localparam int B_CRS    = 7;
    localparam int B_LINK   = 6;
    localparam int B_MABORT = 5;
    localparam int B_POISON = 4;

    localparam logic [STAT_W-1:0] STICKY_MASK =
        (32'h1 << B_VPD)    | (32'h1 << B_PSTATE) | (32'h1 << B_HALT)  |
        (32'h1 << B_SYSERR) | (32'h1 << B_CORTX)  | (32'h1 << B_UNCTX) |
        (32'h1 << B_CRS)    | (32'h1 << B_LINK)   | (32'h1 << B_MABORT) |
        (32'h1 << B_POISON);

    localparam logic [STAT_W-1:0] CFG_SRC_MASK = (32'h1 << B_VPD) | (32'h1 << B_PSTATE);

    // Bits 13:4 without the link-down bit.
    localparam logic [STAT_W-1:0] ERR_SRC_MASK = 32'h0000_3FF0 & ~(32'h1 << B_LINK);

    typedef enum logic [1:0] {
        PS_D0 = 2'd0,
        PS_D1 = 2'd1,
        PS_D2 = 2'd2,
        PS_D3 = 2'd3
    } pstate_e;

endpackage

// File: rtl/evt_irq_pstate.sv
module evt_irq_pstate
    import evt_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic [1:0] state_i,
    output logic       trans_o
);

    pstate_e cur_q;
    pstate_e nxt;

    assign nxt = pstate_e'(state_i);

    // State register: a write moves straight to the written state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= PS_D0;
        end else if (wr_en_i) begin
            cur_q <= nxt;
        end
    end

    // Output: flag only the four qualifying moves.
    always_comb begin
        trans_o = 1'b0;
        if (wr_en_i) begin
            unique case (cur_q)
                PS_D0:   trans_o = (nxt == PS_D3) || (nxt == PS_D1);
                PS_D1:   trans_o = (nxt == PS_D3);
                PS_D2:   trans_o = 1'b0;
                PS_D3:   trans_o = (nxt == PS_D0);
                default: trans_o = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/evt_irq_sticky.sv
module evt_irq_sticky #(
    parameter int                 W    = 32,
    parameter logic [W-1:0]       MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_cell
            logic q;
            // A set in the same cycle as a clear wins.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= 1'b0;
                end else if (set_i[i]) begin
                    q <= 1'b1;
                end else if (clr_i[i]) begin
                    q <= 1'b0;
                end
            end
            assign q_o[i] = q;
        end else begin : g_rsvd
            assign q_o[i] = 1'b0;
        end
    end

    logic sticky_unused;
    assign sticky_unused = ^((set_i | clr_i) & ~MASK);

endmodule

// File: rtl/evt_irq_gate.sv
module evt_irq_gate #(
    parameter int           W   = 32,
    parameter logic [W-1:0] SRC = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] stat_i,
    input  logic [W-1:0] en_i,
    output logic         irq_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= |(stat_i & SRC & en_i);
        end
    end

endmodule

// File: rtl/evt_irq_status.sv
module evt_irq_status
    import evt_irq_pkg::*;
#(
    parameter int ROOT_W = 8,
    parameter int PIE_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [31:0]       wr_data_i,
    output logic [31:0]       status_o,
    input  logic              vpd_addr_wr_i,
    input  logic              pm_wr_en_i,
    input  logic [1:0]        pm_state_i,
    input  logic              halt_on_err_i,
    input  logic              posted_par_err_i,
    input  logic              root_syserr_i,
    input  logic              cor_msg_tx_i,
    input  logic              unc_msg_tx_i,
    input  logic              cfg_retry_i,
    input  logic              link_down_i,
    input  logic              ibus_mabort_i,
    input  logic              poison_rx_i,
    input  logic [ROOT_W-1:0] root_err_sts_i,
    input  logic [PIE_W-1:0]  pie_sts_i,
    input  logic [PIE_W-1:0]  pie_msk_i,
    input  logic [31:0]       cfg_irq_en_i,
    input  logic [31:0]       err_irq_en_i,
    output logic              irq_cfg_o,
    output logic              irq_err_o
);

    logic              ps_trans;
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;
    logic [STAT_W-1:0] sticky_q;
    logic [STAT_W-1:0] live_vec;
    logic              root_live;
    logic              pie_live;

    evt_irq_pstate u_pstate (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (pm_wr_en_i),
        .state_i (pm_state_i),
        .trans_o (ps_trans)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[B_VPD]    = vpd_addr_wr_i;
        set_vec[B_PSTATE] = ps_trans;
        set_vec[B_HALT]   = posted_par_err_i & halt_on_err_i;
        set_vec[B_SYSERR] = root_syserr_i;
        set_vec[B_CORTX]  = cor_msg_tx_i;
        set_vec[B_UNCTX]  = unc_msg_tx_i;
        set_vec[B_CRS]    = cfg_retry_i;
        set_vec[B_LINK]   = link_down_i;
        set_vec[B_MABORT] = ibus_mabort_i;
        set_vec[B_POISON] = poison_rx_i;
    end

    assign clr_vec = wr_en_i ? wr_data_i : '0;

    evt_irq_sticky #(
        .W    (STAT_W),
        .MASK (STICKY_MASK)
    ) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec),
        .clr_i (clr_vec),
        .q_o   (sticky_q)
    );

    // Live read-only bits follow their sources with no storage.
    assign root_live = root_err_sts_i[6] | root_err_sts_i[5] | root_err_sts_i[0];
    assign pie_live  = |(pie_sts_i & ~pie_msk_i);

    logic root_unused;
    assign root_unused = ^root_err_sts_i[4:1];

    if (ROOT_W > 7) begin : g_root_hi
        logic root_hi_unused;
        assign root_hi_unused = ^root_err_sts_i[ROOT_W-1:7];
    end

    always_comb begin
        live_vec         = '0;
        live_vec[B_ROOT] = root_live;
        live_vec[B_PIE]  = pie_live;
    end

    assign status_o = sticky_q | live_vec;

    evt_irq_gate #(
        .W   (STAT_W),
        .SRC (CFG_SRC_MASK)
    ) u_gate_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat_i (status_o),
        .en_i   (cfg_irq_en_i),
        .irq_o  (irq_cfg_o)
    );

    evt_irq_gate #(
        .W   (STAT_W),
        .SRC (ERR_SRC_MASK)
    ) u_gate_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat_i (status_o),
        .en_i   (err_irq_en_i),
        .irq_o  (irq_err_o)
    );

endmodule

// File: rtl/evt_irq_status_chk.sv
module evt_irq_status_chk
    import evt_irq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en_i,
    input logic [31:0] wr_data_i,
    input logic [31:0] status_o,
    input logic        vpd_addr_wr_i,
    input logic        pm_wr_en_i,
    input logic        halt_on_err_i,
    input logic        posted_par_err_i,
    input logic [31:0] cfg_irq_en_i,
    input logic [31:0] err_irq_en_i,
    input logic        irq_cfg_o,
    input logic        irq_err_o
);

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(status_o) & ~($past(wr_en_i) ? $past(wr_data_i) : 32'h0)) & STICKY_MASK) & ~status_o) == 32'h0); // R2

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en_i && wr_data_i[B_VPD] && !vpd_addr_wr_i) |-> !status_o[B_VPD]); // R2

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(vpd_addr_wr_i) |-> status_o[B_VPD]); // R3

    AST_PSTATE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!pm_wr_en_i) && !$past(status_o[B_PSTATE])) |-> !status_o[B_PSTATE]); // R5

    AST_HALT_QUALIFIES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!halt_on_err_i) && !$past(status_o[B_HALT])) |-> !status_o[B_HALT]); // R6

    AST_CFG_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cfg_o == $past(|(status_o & CFG_SRC_MASK & cfg_irq_en_i))); // R11

    AST_ERR_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err_o == $past(|(status_o & ERR_SRC_MASK & err_irq_en_i))); // R12

    logic chk_unused;
    assign chk_unused = posted_par_err_i;

endmodule

bind evt_irq_status evt_irq_status_chk u_chk (.*);

// File: tb/evt_irq_status_tb.sv
module evt_irq_status_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en_i;
    logic [31:0] wr_data_i;
    logic [31:0] status_o;
    logic        vpd_addr_wr_i, pm_wr_en_i, halt_on_err_i, posted_par_err_i;
    logic [1:0]  pm_state_i;
    logic        root_syserr_i, cor_msg_tx_i, unc_msg_tx_i, cfg_retry_i;
    logic        link_down_i, ibus_mabort_i, poison_rx_i;
    logic [7:0]  root_err_sts_i;
    logic [15:0] pie_sts_i, pie_msk_i;
    logic [31:0] cfg_irq_en_i, err_irq_en_i;
    logic        irq_cfg_o, irq_err_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    evt_irq_status u_dut (.*);

    // {evt[8:0], wr, wdata, expected}
    // evt: 8 vpd, 7 parerr, 6 syserr, 5 cor, 4 unc, 3 crs, 2 link, 1 mabort, 0 poison
    localparam logic [73:0] TBL [10] = '{
        {9'h100, 1'b0, 32'h0000_0000, 32'h0002_0000},
        {9'h000, 1'b1, 32'h0002_0000, 32'h0000_0000},
        {9'h005, 1'b0, 32'h0000_0000, 32'h0000_0050},
        {9'h000, 1'b1, 32'h0000_0010, 32'h0000_0040},
        {9'h004, 1'b1, 32'h0000_0040, 32'h0000_0040},
        {9'h000, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000},
        {9'h07A, 1'b0, 32'h0000_0000, 32'h0000_13A0},
        {9'h000, 1'b1, 32'h0000_0000, 32'h0000_13A0},
        {9'h080, 1'b0, 32'h0000_0000, 32'h0000_33A0},
        {9'h000, 1'b1, 32'h0000_33A0, 32'h0000_0000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_evt(input logic [8:0] e);
        {vpd_addr_wr_i, posted_par_err_i, root_syserr_i, cor_msg_tx_i, unc_msg_tx_i,
         cfg_retry_i, link_down_i, ibus_mabort_i, poison_rx_i} = e;
    endtask

    // Drive for one rising edge, then release; returns on a falling edge.
    task automatic step(input logic [8:0] e, input logic wr, input logic [31:0] wd);
        drive_evt(e);
        wr_en_i   = wr;
        wr_data_i = wd;
        @(negedge clk);
        drive_evt(9'h0);
        wr_en_i   = 1'b0;
        wr_data_i = 32'h0;
    endtask

    task automatic pm_write(input logic [1:0] s);
        pm_wr_en_i = 1'b1;
        pm_state_i = s;
        @(negedge clk);
        pm_wr_en_i = 1'b0;
    endtask

    task automatic pm_case(input logic [1:0] s, input logic exp16, input string tag);
        pm_write(s);
        check(tag, {31'h0, status_o[16]}, {31'h0, exp16});
        step(9'h0, 1'b1, 32'h0001_0000);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive_evt(9'h0);
        wr_en_i = 1'b0; wr_data_i = '0;
        pm_wr_en_i = 1'b0; pm_state_i = 2'd0;
        halt_on_err_i = 1'b1;
        root_err_sts_i = '0; pie_sts_i = '0; pie_msk_i = '0;
        cfg_irq_en_i = '0; err_irq_en_i = '0;
        repeat (3) @(negedge clk);
        check("R1 status after reset", status_o, 32'h0);
        check("R1 irq after reset", {30'h0, irq_cfg_o, irq_err_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2 R3 R4 R6 R9 R10
        for (int i = 0; i < 10; i++) begin
            step(TBL[i][73:65], TBL[i][64], TBL[i][63:32]);
            check($sformatf("R2/R3/R4/R9/R10 row %0d", i), status_o, TBL[i][31:0]);
        end

        // R6: halt control low blocks bit 13
        halt_on_err_i = 1'b0;
        step(9'h080, 1'b0, 32'h0);
        check("R6 parity error ignored without halt", status_o, 32'h0);
        halt_on_err_i = 1'b1;

        // R5: power-state moves, tracker starts in D0
        pm_case(2'd1, 1'b1, "R5 D0->D1");
        pm_case(2'd1, 1'b0, "R5 D1->D1 unchanged");
        pm_case(2'd2, 1'b0, "R5 D1->D2");
        pm_case(2'd3, 1'b0, "R5 D2->D3");
        pm_case(2'd0, 1'b1, "R5 D3->D0");
        pm_case(2'd3, 1'b1, "R5 D0->D3");
        pm_case(2'd1, 1'b0, "R5 D3->D1");
        pm_case(2'd3, 1'b1, "R5 D1->D3");
        pm_case(2'd0, 1'b1, "R5 D3->D0 again");
        pm_case(2'd2, 1'b0, "R5 D0->D2");

        // R7: root-error live bit
        root_err_sts_i = 8'h40;
        #1 check("R7 root bit6 source", status_o, 32'h0000_0800);
        step(9'h0, 1'b1, 32'h0000_0800);
        check("R7 write does not clear", status_o, 32'h0000_0800);
        root_err_sts_i = 8'h1E;
        #1 check("R7 other root bits ignored", status_o, 32'h0);
        root_err_sts_i = 8'h01;
        #1 check("R7 root bit0 source", status_o, 32'h0000_0800);
        root_err_sts_i = 8'h00;

        // R8: interface-error live bit
        pie_sts_i = 16'h0005; pie_msk_i = 16'h0005;
        #1 check("R8 fully masked", status_o, 32'h0);
        pie_msk_i = 16'h0004;
        #1 check("R8 unmasked source", status_o, 32'h0000_0400);
        pie_sts_i = 16'h0; pie_msk_i = 16'h0;
        @(negedge clk);

        // R12: error line, live bit 11 with all enables on
        err_irq_en_i = 32'hFFFF_FFFF;
        root_err_sts_i = 8'h20;
        @(negedge clk);
        check("R12 error irq from bit11", {31'h0, irq_err_o}, 32'h1);
        err_irq_en_i = ~32'h0000_0800;
        @(negedge clk);
        check("R12 error irq disabled per bit", {31'h0, irq_err_o}, 32'h0);
        root_err_sts_i = 8'h00;
        err_irq_en_i = 32'hFFFF_FFFF;
        step(9'h004, 1'b0, 32'h0);
        @(negedge clk);
        check("R10 link down bit", status_o, 32'h0000_0040);
        check("R12 link down raises no error irq", {31'h0, irq_err_o}, 32'h0);
        step(9'h001, 1'b0, 32'h0);
        @(negedge clk);
        check("R12 poison raises error irq", {31'h0, irq_err_o}, 32'h1);
        step(9'h0, 1'b1, 32'h0000_0050);
        @(negedge clk);
        check("R12 error irq drops after clear", {31'h0, irq_err_o}, 32'h0);

        // R11: configuration-write line
        cfg_irq_en_i = 32'h0;
        step(9'h100, 1'b0, 32'h0);
        @(negedge clk);
        check("R11 cfg irq masked", {31'h0, irq_cfg_o}, 32'h0);
        cfg_irq_en_i = 32'h0002_0000;
        @(negedge clk);
        check("R11 cfg irq enabled", {31'h0, irq_cfg_o}, 32'h1);
        check("R12 vpd bit not on error line", {31'h0, irq_err_o}, 32'h0);
        step(9'h0, 1'b1, 32'h0002_0000);
        @(negedge clk);
        check("R11 cfg irq drops after clear", {31'h0, irq_cfg_o}, 32'h0);

        // R9: reserved bits after writes of ones
        step(9'h0, 1'b1, 32'hFFFC_C00F);
        check("R9 reserved read zero", status_o, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule